// File: doc/BRIEF.md
# Per-Lane Receive Output Squelch and Polarity Control

This block sits between the data recovery stage of a multi-lane receiver and its output drivers. Each lane brings in a recovered data bit and a loss-of-signal flag. Each lane then leaves the block with a data bit that is either passed through, passed through inverted, or held at a quiet level of 0. A per-lane status bit reports when the lane is being held quiet.

Three control words set the behaviour of each lane. The polarity word selects inversion. The deactivate word forces a lane quiet whatever its input state. The squelch-override word stops loss of signal from quieting a lane. The override has no effect on a lane that is deactivated. A simple single-cycle register port writes and reads these words. A synchronous control clear returns all three words to their defaults without a full reset.

Top module: `lane_squelch_ctrl`

## Requirements
- R1: Each of the `LANES` lanes behaves independently: bit i of the outputs depends only on bit i of the inputs and bit i of each control word.
- R2: For a lane that is not squelched, `tx_data[i]` equals `rx_data[i]` when polarity bit i is 0, and equals its inverse when polarity bit i is 1.
- R3: When deactivate bit i is 1, lane i is squelched whatever the values of `rx_los[i]` and override bit i.
- R4: When `rx_los[i]` is 1 and override bit i is 0, lane i is squelched. When override bit i is 1, loss of signal alone does not squelch the lane.
- R5: A squelched lane drives `tx_data[i]` = 0 whatever its polarity bit and input data.
- R6: `sq_stat[i]` is 1 exactly when lane i is squelched, that is deactivate OR (loss of signal AND NOT override).
- R7: A cycle with `ctl_clr` = 1 sets all three control words to 0 at that clock edge. It wins over a write in the same cycle.
- R8: After `rst_n` is low, all three control words read 0 (normal polarity, lane active, squelch enabled).
- R9: Register map: address 0 is polarity, address 1 is deactivate, address 2 is squelch override (bit i is lane i). `rd_data` shows the word at `addr` in the same cycle. Address 3 reads 0, and a write to it changes nothing.
- R10: A write is captured on the clock edge where `wr_en` is high, and the lane outputs reflect the new value right after that edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_clr | input | 1 | Synchronous clear of all control words |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wr_data | input | LANES | Write data, one bit per lane |
| rd_data | output | LANES | Read data of the addressed word |
| rx_data | input | LANES | Recovered data per lane |
| rx_los | input | LANES | Loss-of-signal flag per lane |
| tx_data | output | LANES | Gated output data per lane |
| sq_stat | output | LANES | Squelch active per lane |

## Verification
The bench builds the block with `LANES` = 4. This makes every combination of the three control words reachable, 4096 configurations in total. Under each configuration the bench drives all four pairings of loss of signal and input data, so every lane sees every one of the 32 combinations of its five inputs. Separate directed steps cover the register map, the unused address, clear priority over a write, and the exact edge at which a written value reaches the outputs.

// File: rtl/lane_squelch_ctrl.sv
module lane_squelch_ctrl #(
  parameter int LANES = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_clr,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [LANES-1:0] wr_data,
  output logic [LANES-1:0] rd_data,
  input  logic [LANES-1:0] rx_data,
  input  logic [LANES-1:0] rx_los,
  output logic [LANES-1:0] tx_data,
  output logic [LANES-1:0] sq_stat
);

  localparam logic [1:0] A_POL   = 2'd0;
  localparam logic [1:0] A_DEACT = 2'd1;
  localparam logic [1:0] A_OVR   = 2'd2;

  logic [LANES-1:0] pol_q, deact_q, ovr_q;
  logic [LANES-1:0] inv_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q   <= '0;
      deact_q <= '0;
      ovr_q   <= '0;
    end else if (ctl_clr) begin
      pol_q   <= '0;
      deact_q <= '0;
      ovr_q   <= '0;
    end else if (wr_en) begin
      if (addr == A_POL)   pol_q   <= wr_data;
      if (addr == A_DEACT) deact_q <= wr_data;
      if (addr == A_OVR)   ovr_q   <= wr_data;
    end
  end

  always_comb begin
    case (addr)
      A_POL:   rd_data = pol_q;
      A_DEACT: rd_data = deact_q;
      A_OVR:   rd_data = ovr_q;
      default: rd_data = '0;
    endcase
  end

  assign inv_data = rx_data ^ pol_q;
  assign sq_stat  = deact_q | (rx_los & ~ovr_q);
  assign tx_data  = inv_data & ~sq_stat;

endmodule

// File: rtl/lane_squelch_ctrl_chk.sv
module lane_squelch_ctrl_chk #(
  parameter int LANES = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_clr,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [LANES-1:0] wr_data,
  input logic [LANES-1:0] rx_data,
  input logic [LANES-1:0] rx_los,
  input logic [LANES-1:0] tx_data,
  input logic [LANES-1:0] sq_stat,
  input logic [LANES-1:0] pol_q,
  input logic [LANES-1:0] deact_q,
  input logic [LANES-1:0] ovr_q
);

  p_quiet_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_data & sq_stat) == '0);

  p_deact_sq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_stat & deact_q) == deact_q);

  p_los_sq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_stat & rx_los & ~ovr_q) == (rx_los & ~ovr_q));

  p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_data ^ rx_data ^ pol_q) & ~sq_stat) == '0);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_clr |=> (pol_q == '0 && deact_q == '0 && ovr_q == '0));

  p_pol_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ctl_clr && addr == 2'd0) |=> pol_q == $past(wr_data));

  p_spare_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ctl_clr && addr == 2'd3) |=>
      ($stable(pol_q) && $stable(deact_q) && $stable(ovr_q)));

endmodule

bind lane_squelch_ctrl lane_squelch_ctrl_chk #(.LANES(LANES)) chk_i (
  .clk(clk), .rst_n(rst_n), .ctl_clr(ctl_clr), .wr_en(wr_en), .addr(addr),
  .wr_data(wr_data), .rx_data(rx_data), .rx_los(rx_los), .tx_data(tx_data),
  .sq_stat(sq_stat), .pol_q(pol_q), .deact_q(deact_q), .ovr_q(ovr_q)
);

// File: tb/lane_squelch_ctrl_tb_top.sv
module lane_squelch_ctrl_tb_top;
  localparam int L = 4;

  logic clk = 0, rst_n = 0, ctl_clr = 0, wr_en = 0;
  logic [1:0] addr = '0;
  logic [L-1:0] wr_data = '0, rx_data = '0, rx_los = '0;
  logic [L-1:0] rd_data, tx_data, sq_stat;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  lane_squelch_ctrl #(.LANES(L)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_clr(ctl_clr), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .rx_data(rx_data), .rx_los(rx_los),
    .tx_data(tx_data), .sq_stat(sq_stat)
  );

  task automatic chk(input string req, input logic [L-1:0] act, input logic [L-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [L-1:0] d);
    wr_en = 1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [L-1:0] exp);
    addr = a; #1;
    chk(req, rd_data, exp);
  endtask

  initial begin
    logic [L-1:0] sq_e, tx_e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R8 reset defaults
    rd("R8 pol", 2'd0, '0);
    rd("R8 deact", 2'd1, '0);
    rd("R8 ovr", 2'd2, '0);
    @(negedge clk);

    // R9 map and spare address
    wr(2'd0, 4'hA); wr(2'd1, 4'h5); wr(2'd2, 4'hC);
    rd("R9 pol", 2'd0, 4'hA);
    rd("R9 deact", 2'd1, 4'h5);
    rd("R9 ovr", 2'd2, 4'hC);
    @(negedge clk);
    wr(2'd3, 4'hF);
    rd("R9 spare reads 0", 2'd3, '0);
    rd("R9 spare write pol", 2'd0, 4'hA);
    rd("R9 spare write deact", 2'd1, 4'h5);
    rd("R9 spare write ovr", 2'd2, 4'hC);
    @(negedge clk);

    // R7 clear beats write
    ctl_clr = 1; wr_en = 1; addr = 2'd0; wr_data = 4'hF;
    @(negedge clk);
    ctl_clr = 0; wr_en = 0;
    rd("R7 pol", 2'd0, '0);
    rd("R7 deact", 2'd1, '0);
    rd("R7 ovr", 2'd2, '0);
    @(negedge clk);

    // R10 timing of a polarity write
    rx_data = 4'h3; rx_los = '0;
    wr_en = 1; addr = 2'd0; wr_data = 4'hF; #1;
    chk("R10 before edge", tx_data, 4'h3);
    @(negedge clk);
    wr_en = 0; #1;
    chk("R10 after edge", tx_data, 4'hC);
    @(negedge clk);

    // R1-style sweep covering R2 R3 R4 R5 R6
    for (int p = 0; p < 16; p++)
      for (int d = 0; d < 16; d++)
        for (int o = 0; o < 16; o++) begin
          wr(2'd0, p[L-1:0]); wr(2'd1, d[L-1:0]); wr(2'd2, o[L-1:0]);
          for (int j = 0; j < 4; j++) begin
            rx_los  = {L{j[1]}} ^ p[L-1:0];
            rx_data = {L{j[0]}} ^ d[L-1:0];
            #1;
            for (int i = 0; i < L; i++) begin
              sq_e[i] = d[i] | (rx_los[i] & ~o[i]);
              tx_e[i] = sq_e[i] ? 1'b0 : (rx_data[i] ^ p[i]);
            end
            chk("R6 R3 R4 sq_stat", sq_stat, sq_e);
            chk("R1 R2 R5 tx_data", tx_data, tx_e);
          end
        end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule